// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Compressed Test Mode

This block is the control side of a four-bit-wide dynamic memory. It samples the active-low row strobe, column strobe, write enable and output enable on a system clock. From the order in which the strobes fall, it sorts each memory cycle into one of these kinds: a read, an early write, a row-only refresh, a column-before-row refresh that takes its row from an internal counter, or a column-before-row refresh with write low, which also switches the part into a compressed test mode. A small behavioural array stands in for the cells. Inside the block every location is eight bits wide, split into a low half and a high half. The top column address bit chooses the half in normal operation.

In test mode both halves behind each data pin are written together. A read then gives a per-pin equality verdict in place of the stored data, so a tester can cover the array at half the address count. Each refresh, of either kind, is announced by a one-clock pulse with the row refreshed. This pulse has no back-pressure: the consumer must take it on the cycle it appears. The data pins are plain, strobe-timed pins with no valid/ready handshake, because the strobes themselves set when data moves.

Top module: `dram_cycle_ctl`

## Requirements
- R1: After reset the mode flag reads normal (test_mode=0), dq_oe=0 and ref_valid=0. The first column-before-row refresh reports row 0.
- R2: In normal mode, a write stores dq_in at the latched row and column, and a later read of that location returns it on dq_out. The top column bit (addr[COL_W-1]) picks the high half (1) or the low half (0), so the two halves are separate locations.
- R3: When we_n is low at the clock where cas_n is first seen low in a row cycle, the cycle is an early write, and dq_oe stays 0 for the whole cycle.
- R4: dq_oe is 1 only during a read cycle while ras_n, cas_n and oe_n are all low. It drops as soon as cas_n or oe_n goes high.
- R5: If cas_n is low at the clock where ras_n is first seen low and we_n is high, the cycle is a refresh. One clock later ref_valid pulses for one clock, with ref_row equal to the internal counter; the address pins are ignored.
- R6: The internal row counter advances by one after every column-before-row cycle, including the test-entry kind, and wraps from 1023 to 0.
- R7: A row cycle that ends (ras_n rises) without a column strobe is a row-only refresh. It pulses ref_valid one clock later with ref_row equal to the row address latched at the row strobe, and it leaves the counter unchanged.
- R8: A column-before-row cycle with we_n low sets test_mode to 1, visible one clock after the row strobe is seen. It also refreshes the counter row.
- R9: A column-before-row cycle with we_n high, or a row-only refresh, returns test_mode to 0.
- R10: In test mode a write ignores the top column bit and stores dq_in into both halves of the addressed location.
- R11: In test mode a read drives, on each data pin, 1 when the two halves' bits for that pin are equal and 0 when they differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row / column address |
| dq_in | input | 4 | Write data |
| dq_out | output | 4 | Read data or test-mode verdict; 0 when not driven |
| dq_oe | output | 1 | Data pins driven |
| test_mode | output | 1 | 1 while in compressed test mode |
| ref_valid | output | 1 | One-clock pulse per refresh |
| ref_row | output | ROW_W | Row refreshed, valid with ref_valid |

## Verification
The assertions take for granted that the strobes arrive already synchronised to clk. They also assume each strobe level lasts at least one clock, so that a row strobe fall and the following rise never land on the same sample. The bench drives every input only on falling clock edges and holds each strobe level for at least one full clock. Every row cycle it issues is closed by ras_n going high before the next cycle begins, so the one-clock refresh pulse and the counter step are never asked to happen on back-to-back clocks.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_CBR  = 2'd2
  } dcd_state_e;

  localparam int unsigned DQ_W = 4;
endpackage

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] count
);
  localparam logic [ROW_W-1:0] ONE = {{(ROW_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (inc) count <= count + ONE;
  end

  assert_ctr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == $past(count) + ONE);

  assert_ctr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/dcd_strobe_fsm.sv
module dcd_strobe_fsm
  import dcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ROW_W-1:0]  ctr_val,
  output logic              ctr_inc,
  output logic              wr_en,
  output logic              rd_act,
  output logic              test_mode,
  output logic              ref_valid,
  output logic [ROW_W-1:0]  ref_row,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q
);
  dcd_state_e state;
  logic ras_q, cas_q, cas_seen;
  logic ras_fall, cas_fall;

  assign ras_fall = ras_q & ~ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign ctr_inc  = (state == ST_IDLE) & ras_fall & ~cas_n;
  assign wr_en    = (state == ST_ROW) & ~ras_n & cas_fall & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      cas_seen  <= 1'b0;
      rd_act    <= 1'b0;
      test_mode <= 1'b0;
      ref_valid <= 1'b0;
      ref_row   <= '0;
      row_q     <= '0;
      col_q     <= '0;
    end else begin
      ras_q     <= ras_n;
      cas_q     <= cas_n;
      ref_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ras_fall) begin
            if (!cas_n) begin
              state     <= ST_CBR;
              ref_valid <= 1'b1;
              ref_row   <= ctr_val;
              test_mode <= ~we_n;
            end else begin
              state    <= ST_ROW;
              row_q    <= addr[ROW_W-1:0];
              cas_seen <= 1'b0;
            end
          end
        end
        ST_ROW: begin
          if (ras_n) begin
            state  <= ST_IDLE;
            rd_act <= 1'b0;
            if (!cas_seen) begin
              ref_valid <= 1'b1;
              ref_row   <= row_q;
              test_mode <= 1'b0;
            end
          end else if (cas_fall) begin
            col_q    <= addr[COL_W-1:0];
            cas_seen <= 1'b1;
            rd_act   <= we_n;
          end
        end
        ST_CBR: begin
          if (ras_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ref_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> !ref_valid);

  assert_early_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_act);

  assert_test_entry_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> ref_valid);

  assert_test_exit_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_mode) |-> ref_valid);
endmodule

// File: rtl/dcd_array.sv
module dcd_array
  import dcd_pkg::*;
#(
  parameter int unsigned ARR_ROW_W = 2,
  parameter int unsigned COL_W     = 4
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic                 test,
  input  logic [ARR_ROW_W-1:0] row,
  input  logic [COL_W-1:0]     wr_col,
  input  logic [COL_W-1:0]     rd_col,
  input  logic [DQ_W-1:0]      wdata,
  output logic [DQ_W-1:0]      rdata
);
  localparam int unsigned IDX_W = ARR_ROW_W + COL_W - 1;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [DQ_W-1:0]  half_rd [2];

  assign wr_idx = {row, wr_col[COL_W-2:0]};
  assign rd_idx = {row, rd_col[COL_W-2:0]};

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DQ_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (test || (wr_col[COL_W-1] == 1'(h))))
        cells[wr_idx] <= wdata;
    end
    assign half_rd[h] = cells[rd_idx];
  end

  always_comb begin
    if (test) rdata = ~(half_rd[0] ^ half_rd[1]);
    else      rdata = rd_col[COL_W-1] ? half_rd[1] : half_rd[0];
  end
endmodule

// File: rtl/dram_cycle_ctl.sv
module dram_cycle_ctl
  import dcd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned COL_W     = 4,
  parameter int unsigned ARR_ROW_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        dq_in,
  output logic [3:0]        dq_out,
  output logic              dq_oe,
  output logic              test_mode,
  output logic              ref_valid,
  output logic [ROW_W-1:0]  ref_row
);
  logic             ctr_inc, wr_en, rd_act;
  logic [ROW_W-1:0] ctr_val, row_q;
  logic [COL_W-1:0] col_q;
  logic [DQ_W-1:0]  rdata;

  dcd_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(ctr_inc), .count(ctr_val)
  );

  dcd_strobe_fsm #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ctr_val(ctr_val), .ctr_inc(ctr_inc), .wr_en(wr_en),
    .rd_act(rd_act), .test_mode(test_mode), .ref_valid(ref_valid),
    .ref_row(ref_row), .row_q(row_q), .col_q(col_q)
  );

  dcd_array #(.ARR_ROW_W(ARR_ROW_W), .COL_W(COL_W)) u_arr (
    .clk(clk), .wr_en(wr_en), .test(test_mode), .row(row_q[ARR_ROW_W-1:0]),
    .wr_col(addr[COL_W-1:0]), .rd_col(col_q), .wdata(dq_in), .rdata(rdata)
  );

  assign dq_oe  = rd_act & ~ras_n & ~cas_n & ~oe_n;
  assign dq_out = dq_oe ? rdata : '0;

  assert_no_drive_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !dq_oe);
endmodule

// File: tb/dram_cycle_ctl_bench.sv
module dram_cycle_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out;
  logic dq_oe, test_mode, ref_valid;
  logic [9:0] ref_row;
  int checks = 0, failures = 0;
  int exp_ctr = 0;
  logic [3:0] rd_v;
  logic rd_oe;

  always #5 clk = ~clk;

  dram_cycle_ctl u_dram_cycle_ctl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .test_mode(test_mode), .ref_valid(ref_valid), .ref_row(ref_row)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int row, input int col, input logic [3:0] d);
    ras_n = 1'b0; addr = 10'(row); tick();
    addr = 10'(col); we_n = 1'b0; dq_in = d; cas_n = 1'b0; tick();
    chk(dq_oe == 1'b0, "R3 early write drive", int'(dq_oe), 0);
    oe_n = 1'b0; tick();
    chk(dq_oe == 1'b0, "R3 early write drive oe low", int'(dq_oe), 0);
    oe_n = 1'b1; cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; tick();
  endtask

  task automatic rd(input int row, input int col, input logic oe, output logic [3:0] v, output logic o);
    ras_n = 1'b0; addr = 10'(row); tick();
    addr = 10'(col); oe_n = oe; cas_n = 1'b0; tick();
    v = dq_out; o = dq_oe;
    cas_n = 1'b1; tick();
    chk(dq_oe == 1'b0, "R4 cas high", int'(dq_oe), 0);
    oe_n = 1'b1; ras_n = 1'b1; tick();
  endtask

  task automatic cbr(input logic we);
    cas_n = 1'b0; we_n = we; tick();
    ras_n = 1'b0; addr = 10'h3FF; tick();
    chk(ref_valid == 1'b1, "R5 refresh pulse", int'(ref_valid), 1);
    chk(ref_row == 10'(exp_ctr), "R6 counter row", int'(ref_row), exp_ctr);
    chk(test_mode == !we, we ? "R9 cbr mode" : "R8 test entry", int'(test_mode), int'(!we));
    exp_ctr = (exp_ctr + 1) % 1024;
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick();
    chk(ref_valid == 1'b0, "R5 pulse width", int'(ref_valid), 0);
    tick();
  endtask

  task automatic ror(input int row);
    ras_n = 1'b0; addr = 10'(row); tick(); tick();
    ras_n = 1'b1; tick();
    chk(ref_valid == 1'b1, "R7 ror pulse", int'(ref_valid), 1);
    chk(ref_row == 10'(row), "R7 ror row", int'(ref_row), row);
    chk(test_mode == 1'b0, "R9 ror exits test", int'(test_mode), 0);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1; tick();
    chk(test_mode == 1'b0, "R1 mode", int'(test_mode), 0);
    chk(dq_oe == 1'b0, "R1 oe", int'(dq_oe), 0);
    chk(ref_valid == 1'b0, "R1 ref", int'(ref_valid), 0);
    cbr(1'b1);  // R1: first counter row is 0

    // R2: exhaustive normal sweep over array rows and every column
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++)
        wr(r, c, 4'((r * 5 + c * 3 + 1) & 15));
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++) begin
        rd(r, c, 1'b0, rd_v, rd_oe);
        chk(rd_oe == 1'b1, "R4 read drives", int'(rd_oe), 1);
        chk(rd_v == 4'((r * 5 + c * 3 + 1) & 15), "R2 read data", int'(rd_v), (r * 5 + c * 3 + 1) & 15);
      end

    rd(1, 3, 1'b1, rd_v, rd_oe);
    chk(rd_oe == 1'b0, "R4 oe high", int'(rd_oe), 0);

    ror(10'h2A5);
    cbr(1'b1);  // R7: counter untouched by row-only refresh

    // R11: halves differ
    wr(1, 2, 4'h3);
    wr(1, 10, 4'h5);
    cbr(1'b0);
    rd(1, 2, 1'b0, rd_v, rd_oe);
    chk(rd_v == 4'h9, "R11 compare differ", int'(rd_v), 9);
    // R10: test write fills both halves
    wr(2, 5, 4'hA);
    rd(2, 13, 1'b0, rd_v, rd_oe);
    chk(rd_v == 4'hF, "R11 compare equal", int'(rd_v), 15);
    ror(7);
    rd(2, 5, 1'b0, rd_v, rd_oe);
    chk(rd_v == 4'hA, "R10 low half", int'(rd_v), 10);
    rd(2, 13, 1'b0, rd_v, rd_oe);
    chk(rd_v == 4'hA, "R10 high half", int'(rd_v), 10);

    cbr(1'b0);
    cbr(1'b1);  // R9 exit via plain refresh

    // R6: run the counter past its wrap
    for (int i = 0; i < 1030; i++) cbr(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule